// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slower clock whose average frequency no single whole-number ratio can reach, for example a 32.768 kHz low-power timebase taken from a reference in the megahertz range. It switches between two whole-number divisors. The first divisor is held for a programmed number of output periods, and then the second divisor is held for its own programmed count. Over one full sequence the mean ratio is therefore fractional.

Four fields set the behaviour: a primary divisor, a primary repeat count, a secondary divisor and a secondary repeat count. A mode bit picks plain single-divisor operation or the alternating dual operation. The block drives a divided clock level, plus a strobe one reference cycle wide that marks the first cycle of every output period. Downstream logic can use the strobe as a clock enable instead of the divided level. The block captures a new configuration only when a full sequence ends, so a sequence never mixes old and new settings.

Top module: `fracdiv_dual`

## Requirements
- R1: While `rst_ni` is low, both outputs are 0. The first rising edge after release samples the configuration inputs. `tick_o` is first high after the second rising edge following release, and a period of the primary divisor starts there.
- R2: Every field holds its value minus one: a divisor field value d means a period of d+1 reference cycles, and a repeat field value r means r+1 periods. A field value of 0 means 1.
- R3: With `dual_en_i` = 0 every output period uses the primary divisor. The primary repeat count and both secondary fields have no effect on the outputs.
- R4: With `dual_en_i` = 1 the block emits (primary repeat) periods of the primary divisor, then (secondary repeat) periods of the secondary divisor, and repeats this in that order. Over one sequence the average output rate is fin·(M1+M2)/(N1·M1+N2·M2), where N and M are the actual divisor and repeat values.
- R5: In a period of N cycles, `clk_div_o` is high for the first floor(N/2) cycles and low for the rest. When N is 1 it stays high.
- R6: `tick_o` is high for exactly the first reference cycle of every output period and low at all other times.
- R7: The block samples all four fields and the mode bit only at the end of a sequence. In dual mode that is the last cycle of the last secondary period. In single mode it is the last cycle of each period. Changes at any other time have no effect on the outputs.
- R8: A change of `dual_en_i` takes effect from the first period after the current sequence ends, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronous release assumed |
| dual_en_i | input | 1 | 1 = alternate the two divisors, 0 = primary divisor only |
| div_a_i | input | DIV_W | Primary divisor minus one |
| rep_a_i | input | REP_W | Primary repeat count minus one |
| div_b_i | input | DIV_W | Secondary divisor minus one |
| rep_b_i | input | REP_W | Secondary repeat count minus one |
| clk_div_o | output | 1 | Divided clock level |
| tick_o | output | 1 | One-cycle strobe at the first cycle of each output period |

## Verification
The assertions assume that `rst_ni` is released on a clock edge from a synchronizer outside the block. They also assume that the configuration inputs never hold unknown values at the clock edge where a sequence ends. The bench meets both conditions: it changes reset and every configuration input only on the falling edge of the reference, and it always drives defined values. Configuration inputs may change at any time, including in the middle of a sequence. The bench therefore drives arbitrary small values mid-sequence while its reference model samples them only at sequence ends. It keeps the divisors and repeat counts small, so that each sequence stays within a few dozen cycles.

// File: rtl/fdd_pkg.sv
package fdd_pkg;

  // Which divisor the sequencer is currently applying.
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } fdd_phase_e;

endpackage

// File: rtl/fdd_cfg_hold.sv
// Shadow copy of the configuration; refreshed only when load_i is high.
module fdd_cfg_hold #(
  parameter int DW = 12,
  parameter int RW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dual_i,
  input  logic [DW-1:0] na_i,
  input  logic [RW-1:0] ma_i,
  input  logic [DW-1:0] nb_i,
  input  logic [RW-1:0] mb_i,
  output logic          dual_o,
  output logic [DW-1:0] na_o,
  output logic [RW-1:0] ma_o,
  output logic [DW-1:0] nb_o,
  output logic [RW-1:0] mb_o
);

  logic          dual_q, dual_d;
  logic [DW-1:0] na_q, na_d, nb_q, nb_d;
  logic [RW-1:0] ma_q, ma_d, mb_q, mb_d;

  always_comb begin
    dual_d = dual_q;
    na_d   = na_q;
    ma_d   = ma_q;
    nb_d   = nb_q;
    mb_d   = mb_q;
    if (load_i) begin
      dual_d = dual_i;
      na_d   = na_i;
      ma_d   = ma_i;
      nb_d   = nb_i;
      mb_d   = mb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dual_q <= 1'b0;
      na_q   <= '0;
      ma_q   <= '0;
      nb_q   <= '0;
      mb_q   <= '0;
    end else begin
      dual_q <= dual_d;
      na_q   <= na_d;
      ma_q   <= ma_d;
      nb_q   <= nb_d;
      mb_q   <= mb_d;
    end
  end

  assign dual_o = dual_q;
  assign na_o   = na_q;
  assign ma_o   = ma_q;
  assign nb_o   = nb_q;
  assign mb_o   = mb_q;

endmodule

// File: rtl/fdd_period_ctr.sv
// Position inside the current output period; wraps after nsel_i.
module fdd_period_ctr #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] nsel_i,
  output logic [DW-1:0] pcnt_o,
  output logic          prd_end_o
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] pcnt_q, pcnt_d;
  logic          last_cyc;

  assign last_cyc  = (pcnt_q == nsel_i);
  assign prd_end_o = en_i && last_cyc;

  always_comb begin
    pcnt_d = pcnt_q;
    if (en_i) begin
      if (last_cyc) pcnt_d = '0;
      else          pcnt_d = pcnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end

  assign pcnt_o = pcnt_q;

  AST_PCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (pcnt_q <= nsel_i)); // R2

  AST_PERIOD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_end_o |=> (pcnt_q == '0)); // R6

endmodule

// File: rtl/fdd_phase_seq.sv
// Repeat counter and divisor selection; flags the end of a full sequence.
module fdd_phase_seq
  import fdd_pkg::*;
#(
  parameter int RW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dual_i,
  input  logic [RW-1:0] ma_i,
  input  logic [RW-1:0] mb_i,
  input  logic          prd_end_i,
  output logic          running_o,
  output fdd_phase_e    phase_o,
  output logic          seq_end_o
);

  localparam logic [RW-1:0] ONE = RW'(1);

  logic          run_q, run_d;
  fdd_phase_e    ph_q, ph_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic [RW-1:0] msel;
  logic          last_rep;

  assign msel     = (ph_q == PH_A) ? ma_i : mb_i;
  assign last_rep = (rcnt_q == msel);

  assign seq_end_o = run_q && prd_end_i &&
                     (!dual_i || (last_rep && (ph_q == PH_B)));

  always_comb begin
    run_d  = run_q;
    ph_d   = ph_q;
    rcnt_d = rcnt_q;
    if (!run_q) begin
      run_d  = 1'b1;
      ph_d   = PH_A;
      rcnt_d = '0;
    end else if (prd_end_i) begin
      if (!dual_i) begin
        ph_d   = PH_A;
        rcnt_d = '0;
      end else if (last_rep) begin
        rcnt_d = '0;
        ph_d   = (ph_q == PH_A) ? PH_B : PH_A;
      end else begin
        rcnt_d = rcnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= PH_A;
      rcnt_q <= '0;
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign running_o = run_q;
  assign phase_o   = ph_q;

  AST_REP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && dual_i) |-> (rcnt_q <= msel)); // R4

  AST_SINGLE_STAYS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !dual_i) |-> (ph_q == PH_A)); // R3

endmodule

// File: rtl/fdd_wave_gen.sv
// Registered output stage: period strobe and divided clock level.
module fdd_wave_gen #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          running_i,
  input  logic [DW-1:0] pcnt_i,
  input  logic [DW-1:0] nsel_i,
  output logic          tick_o,
  output logic          clk_o
);

  localparam logic [DW:0] ONE_EXT = (DW+1)'(1);

  logic [DW:0] n_len;
  logic [DW:0] hi_len;
  logic        tick_q, tick_d;
  logic        clk_q, clk_d;

  assign n_len  = {1'b0, nsel_i} + ONE_EXT;
  assign hi_len = (nsel_i == '0) ? ONE_EXT : (n_len >> 1);

  always_comb begin
    tick_d = running_i && (pcnt_i == '0);
    clk_d  = running_i && ({1'b0, pcnt_i} < hi_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      clk_q  <= clk_d;
    end
  end

  assign tick_o = tick_q;
  assign clk_o  = clk_q;

endmodule

// File: rtl/fracdiv_dual.sv
module fracdiv_dual
  import fdd_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int REP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dual_en_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [REP_W-1:0] rep_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  input  logic [REP_W-1:0] rep_b_i,
  output logic             clk_div_o,
  output logic             tick_o
);

  logic             c_dual;
  logic [DIV_W-1:0] c_na, c_nb, nsel, pcnt;
  logic [REP_W-1:0] c_ma, c_mb;
  logic             running, prd_end, seq_end, load;
  fdd_phase_e       phase;

  // Capture on the first cycle after reset and at every sequence end.
  assign load = !running || seq_end;
  assign nsel = (phase == PH_A) ? c_na : c_nb;

  fdd_cfg_hold #(.DW(DIV_W), .RW(REP_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dual_i (dual_en_i),
    .na_i   (div_a_i),
    .ma_i   (rep_a_i),
    .nb_i   (div_b_i),
    .mb_i   (rep_b_i),
    .dual_o (c_dual),
    .na_o   (c_na),
    .ma_o   (c_ma),
    .nb_o   (c_nb),
    .mb_o   (c_mb)
  );

  fdd_period_ctr #(.DW(DIV_W)) u_prd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (running),
    .nsel_i    (nsel),
    .pcnt_o    (pcnt),
    .prd_end_o (prd_end)
  );

  fdd_phase_seq #(.RW(REP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dual_i    (c_dual),
    .ma_i      (c_ma),
    .mb_i      (c_mb),
    .prd_end_i (prd_end),
    .running_o (running),
    .phase_o   (phase),
    .seq_end_o (seq_end)
  );

  fdd_wave_gen #(.DW(DIV_W)) u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .running_i (running),
    .pcnt_i    (pcnt),
    .nsel_i    (nsel),
    .tick_o    (tick_o),
    .clk_o     (clk_div_o)
  );

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !seq_end) |=> ($stable(c_dual) && $stable(c_na) && $stable(c_ma)
                               && $stable(c_nb) && $stable(c_mb))); // R7

  AST_TICK_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> clk_div_o); // R5

endmodule

// File: tb/sim_fracdiv_dual.sv
module sim_fracdiv_dual;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int RW = 12;
  localparam int WATCHDOG = 50000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dual = 1'b0;
  logic [DW-1:0] na = '0, nb = '0;
  logic [RW-1:0] ma = '0, mb = '0;
  logic          tick, dclk;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  string tag = "R1";

  logic [1:0] q[$];
  logic [1:0] cur = 2'b00;
  logic [1:0] expv = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracdiv_dual #(.DIV_W(DW), .REP_W(RW)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dual_en_i (dual),
    .div_a_i   (na),
    .rep_a_i   (ma),
    .div_b_i   (nb),
    .rep_b_i   (mb),
    .clk_div_o (dclk),
    .tick_o    (tick)
  );

  function automatic int hi_of(int n);
    return (n == 1) ? 1 : n / 2;
  endfunction

  task automatic push_period(int n);
    for (int p = 0; p < n; p++)
      q.push_back({(p == 0) ? 1'b1 : 1'b0, (p < hi_of(n)) ? 1'b1 : 1'b0});
  endtask

  task automatic push_seq();
    int n1 = int'(na) + 1;
    int m1 = int'(ma) + 1;
    int n2 = int'(nb) + 1;
    int m2 = int'(mb) + 1;
    if (!dual) begin
      push_period(n1);
    end else begin
      for (int r = 0; r < m1; r++) push_period(n1);
      for (int r = 0; r < m2; r++) push_period(n2);
    end
  endtask

  // Reference model: a queue of per-cycle {tick,clk}; refilled at sequence ends.
  always @(posedge clk) begin
    if (rst_n) begin
      expv = cur;
      if (q.size() == 0) push_seq();
      cur = q.pop_front();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({tick, dclk} !== expv) begin
        errors++;
        $display("FAIL %s: {tick,clk} actual %b%b expected %b at cycle %0d",
                 tag, tick, dclk, expv, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int tcnt;
    int hcnt;
    // R1: reset state
    run(3);
    checks++;
    if ({tick, dclk} !== 2'b00) begin
      errors++;
      $display("FAIL R1: reset outputs actual %b%b expected 00", tick, dclk);
    end

    // R1/R3: single mode, N=5, other fields are junk
    tag  = "R1/R3";
    dual = 1'b0; na = 12'd4; ma = 12'd7; nb = 12'd2; mb = 12'd3;
    rst_n = 1'b1;
    run(40);

    // R2/R4/R6: dual N1=3 x2, N2=4 x1
    @(negedge clk);
    tag = "R2/R4/R6";
    dual = 1'b1; na = 12'd2; ma = 12'd1; nb = 12'd3; mb = 12'd0;
    run(30);
    // R4: sequence of 10 cycles holds 3 periods and 4 high cycles
    tcnt = 0; hcnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick) tcnt++;
      if (dclk) hcnt++;
    end
    checks++;
    if (tcnt != 30 || hcnt != 40) begin
      errors++;
      $display("FAIL R4: ticks/high actual %0d/%0d expected 30/40", tcnt, hcnt);
    end

    // R5: N=1 phases in dual mode, then N=1 single
    tag = "R5";
    dual = 1'b1; na = 12'd0; ma = 12'd2; nb = 12'd1; mb = 12'd1;
    run(40);
    dual = 1'b0; na = 12'd0;
    run(20);
    na = 12'd6;
    run(30);

    // R7: longer sequence with inputs changing mid-sequence
    tag = "R7";
    dual = 1'b1; na = 12'd5; ma = 12'd3; nb = 12'd6; mb = 12'd2;
    run(50);
    for (int k = 0; k < 60; k++) begin
      na = DW'($urandom_range(7));
      ma = RW'($urandom_range(3));
      nb = DW'($urandom_range(7));
      mb = RW'($urandom_range(3));
      run(int'($urandom_range(5)) + 1);
    end
    run(150);

    // R8: mode switches both ways
    tag = "R8";
    na = 12'd3; ma = 12'd2; nb = 12'd4; mb = 12'd1;
    dual = 1'b0;
    run(60);
    dual = 1'b1;
    run(80);
    dual = 1'b0;
    run(40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule